// File: doc/BRIEF.md
# Descriptor-Driven Single-Channel Copy Engine

This block runs one memory-to-memory copy channel from a transfer descriptor kept in local registers. A kick pulse hands the engine a memory address. The engine reads an eight-word descriptor from that address. If the descriptor asks to start, the engine then moves data in beads of 1, 2, 4, 16 or 32 bytes over a single request/grant memory port. Source and destination addresses step by their own signed offsets. An inner (minor) loop moves a fixed byte count. An outer (major) counter repeats the minor loop.

When a major loop ends, one of two things happens:
- With chaining off, the engine applies end-of-loop address adjustments, reloads the counter from the beginning count and reports done.
- With chaining on, the last-destination field is used as the address of the next descriptor. The engine fetches that descriptor and carries on without software help.

Interrupts can be requested at the half-way point of the major loop and at its end. A go pulse restarts the descriptor already held, using the adjusted addresses.

The controller has six states:
- IDLE waits for a kick or a go pulse. It moves to FETCH on kick and to CHECK on go.
- FETCH reads descriptor words 0..7. After word 7 it moves to CHECK.
- CHECK validates the descriptor. It moves to READ if the descriptor is valid and started, and to IDLE if not started or invalid.
- READ holds a source read until grant, then moves to WRITE.
- WRITE holds a destination write until grant. It then moves to READ, or to MINOR after the last bead of the minor loop.
- MINOR steps the major count. It moves to READ for another minor loop, to FETCH when chaining, and to IDLE after the last major iteration.

Top module: `dmae_channel`

## Requirements
- R1: After reset, active, done, irq and cfg_err are 0 and no memory request is made.
- R2: A kick in IDLE fetches eight 32-bit little-endian words from kick_addr+4*k. The word layout is:

  | Word | Bits | Field |
  |------|------|-------|
  | 0 | all | source address |
  | 1 | all | destination address |
  | 2 | all | minor byte count |
  | 3 | all | last-source adjustment |
  | 4 | all | last-destination adjustment or next-descriptor address |
  | 5 | [31:16] | signed source offset |
  | 5 | [15:0] | signed destination offset |
  | 6 | [24:16] | current major count |
  | 6 | [8:0] | beginning major count |
  | 7 | [2:0] | source size code |
  | 7 | [6:4] | destination size code |
  | 7 | bit 8 | start |
  | 7 | bit 9 | chaining enable |
  | 7 | bit 10 | major interrupt |
  | 7 | bit 11 | half interrupt |

- R3: A descriptor whose start bit is 0 moves no data. Fetched by a kick, it leaves done and cfg_err at 0.
- R4: Size codes are 0=1, 1=2, 2=4, 4=16 and 5=32 bytes. One bead reads size bytes at the source address and writes them at the destination address. The data sits in the low byte lanes, with mem_be set for exactly those lanes.
- R5: After each bead, the source and destination addresses each add their own sign-extended 16-bit offset.
- R6: A minor loop moves byte count bytes. The major loop runs the current major count of minor loops, with no extra address adjustment between minor loops.
- R7: At major completion without chaining:
  - the last-source and last-destination adjustments are added to the addresses;
  - the major count reloads from the beginning count;
  - done is set.

  A go pulse in IDLE restarts the held descriptor from that state.
- R8: With chaining on, major completion fetches the next descriptor from the last-destination field. A fetched descriptor with start set runs at once, with done held low. A chained descriptor with start clear stops the engine with done set.
- R9: A one-cycle irq pulse marks major completion only when that descriptor's major interrupt bit is set.
- R10: With the half interrupt bit set, irq pulses when the remaining major count drops to half the beginning count (rounded down), if that value is non-zero.
- R11: Any of the following stops the channel in CHECK with cfg_err set and moves no data:
  - an unlisted size code;
  - unequal source and destination sizes;
  - a zero byte count;
  - a byte count that is not a multiple of the bead size;
  - a zero major count.
- R12: active rises in CHECK before the first bead and stays high across chained fetches. It falls when done or cfg_err is set. Every write happens with active high.
- R13: A memory request keeps its address and direction unchanged until granted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kick | input | 1 | Fetch a descriptor and run it (IDLE only) |
| kick_addr | input | 32 | Descriptor address for kick |
| go | input | 1 | Restart the held descriptor (IDLE only) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address |
| mem_size | output | 3 | Size code of the access |
| mem_wdata | output | DATA_W | Write data, low lanes |
| mem_be | output | DATA_W/8 | Byte lane enables for writes |
| mem_gnt | input | 1 | Grant; read data is valid in the grant cycle |
| mem_rdata | input | DATA_W | Read data, low lanes |
| active | output | 1 | Channel transferring |
| done | output | 1 | Last major loop finished |
| irq | output | 1 | Interrupt pulse |
| cfg_err | output | 1 | Descriptor configuration error |

## Verification
The assertions check several things on every cycle:
- an ungranted request holds its address and direction;
- done and active are never high together;
- an error or done state issues no memory traffic;
- every write occurs while active;
- irq is never high for two cycles running.

Only the bench scenarios can show the data behaviour, by comparing final memory with a model:
- byte-exact copies for each size code, including negative and strided offsets;
- the end-of-loop adjustments seen through a go restart;
- chaining across several descriptors, and a chain stopped by a clear start bit;
- the exact number of half and major interrupts;
- rejection of each malformed descriptor.

// File: rtl/dmae_pkg.sv
package dmae_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_CHECK,
        ST_READ,
        ST_WRITE,
        ST_MINOR
    } state_t;

    // descriptor image: eight 32-bit words
    localparam int DESC_WORDS = 8;
    localparam int WIDX_W     = $clog2(DESC_WORDS);
    localparam int CNT_W      = 9;

    // flag bit positions inside word 7
    localparam int FLG_START = 8;
    localparam int FLG_CHAIN = 9;
    localparam int FLG_IMAJ  = 10;
    localparam int FLG_IHALF = 11;

    typedef struct packed {
        logic [31:0]      src;
        logic [31:0]      dst;
        logic [31:0]      nbytes;
        logic [31:0]      src_adj;
        logic [31:0]      dst_adj;   // next descriptor address when chaining
        logic [15:0]      src_step;
        logic [15:0]      dst_step;
        logic [CNT_W-1:0] begin_cnt;
        logic [2:0]       src_code;
        logic [2:0]       dst_code;
        logic             start;
        logic             chain;
        logic             irq_major;
        logic             irq_half;
    } desc_t;

    // bytes per bead for a size code, zero for unlisted codes
    function automatic logic [5:0] bead_bytes(input logic [2:0] code);
        case (code)
            3'd0:    bead_bytes = 6'd1;
            3'd1:    bead_bytes = 6'd2;
            3'd2:    bead_bytes = 6'd4;
            3'd4:    bead_bytes = 6'd16;
            3'd5:    bead_bytes = 6'd32;
            default: bead_bytes = 6'd0;
        endcase
    endfunction

endpackage

// File: rtl/dmae_cfg_check.sv
module dmae_cfg_check
    import dmae_pkg::*;
(
    input  desc_t            desc,
    input  logic [CNT_W-1:0] cur_cnt,
    output logic             cfg_ok,
    output logic [5:0]       bead
);
    logic [31:0] bead_mask;

    always_comb begin
        bead      = bead_bytes(desc.src_code);
        bead_mask = {26'd0, bead} - 32'd1;
        cfg_ok    = (bead != 6'd0)
                 && (desc.src_code == desc.dst_code)
                 && (desc.nbytes != 32'd0)
                 && (cur_cnt != '0)
                 && ((desc.nbytes & bead_mask) == 32'd0);
    end

endmodule

// File: rtl/dmae_strobe.sv
module dmae_strobe #(
    parameter int LANES = 32
) (
    input  logic [5:0]       bead,
    output logic [LANES-1:0] be
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign be[i] = (32'(i) < {26'd0, bead});
    end
endmodule

// File: rtl/dmae_major_ctr.sv
module dmae_major_ctr #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    input  logic [W-1:0] begin_cnt,
    output logic [W-1:0] count,
    output logic         last,
    output logic         half_hit
);
    logic [W-1:0] count_q;
    logic [W-1:0] next_val;

    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= '0;
        else if (load)
            count_q <= load_val;
        else if (dec)
            count_q <= next_val;
    end

    always_comb begin
        next_val = count_q - W'(1);
        last     = (count_q == W'(1));
        half_hit = (count_q > W'(1)) && (next_val == (begin_cnt >> 1));
    end

    assign count = count_q;

endmodule

// File: rtl/dmae_channel.sv
module dmae_channel
    import dmae_pkg::*;
#(
    parameter int DATA_W = 256,            // must hold a 32-byte bead
    localparam int LANES = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kick,
    input  logic [31:0]       kick_addr,
    input  logic              go,
    output logic              mem_req,
    output logic              mem_we,
    output logic [31:0]       mem_addr,
    output logic [2:0]        mem_size,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [LANES-1:0]  mem_be,
    input  logic              mem_gnt,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              active,
    output logic              done,
    output logic              irq,
    output logic              cfg_err
);
    state_t state_q, state_d;

    desc_t              desc_q;
    logic [31:0]        fptr_q;
    logic [WIDX_W-1:0]  widx_q;
    logic [31:0]        remain_q;
    logic [DATA_W-1:0]  rdbuf_q;
    logic               chained_q;
    logic               active_q, done_q, irq_q, err_q;

    logic               cfg_ok;
    logic [5:0]         bead;
    logic [LANES-1:0]   be_all;
    logic [CNT_W-1:0]   cur_cnt;
    logic               cnt_last, cnt_half;
    logic               cnt_load, cnt_dec;
    logic [CNT_W-1:0]   cnt_load_val;
    logic [31:0]        word;
    logic               fetch_last, minor_last_bead;

    assign word            = mem_rdata[31:0];
    assign fetch_last      = (widx_q == WIDX_W'(DESC_WORDS - 1));
    assign minor_last_bead = (remain_q == {26'd0, bead});

    dmae_cfg_check u_check (
        .desc    (desc_q),
        .cur_cnt (cur_cnt),
        .cfg_ok  (cfg_ok),
        .bead    (bead)
    );

    dmae_strobe #(.LANES(LANES)) u_strobe (
        .bead (bead),
        .be   (be_all)
    );

    always_comb begin
        cnt_load     = 1'b0;
        cnt_load_val = desc_q.begin_cnt;
        if (state_q == ST_FETCH && mem_gnt && widx_q == WIDX_W'(6)) begin
            cnt_load     = 1'b1;
            cnt_load_val = word[16 +: CNT_W];
        end else if (state_q == ST_MINOR && cnt_last && !desc_q.chain) begin
            cnt_load = 1'b1;
        end
        cnt_dec = (state_q == ST_MINOR);
    end

    dmae_major_ctr #(.W(CNT_W)) u_major (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (cnt_load),
        .load_val  (cnt_load_val),
        .dec       (cnt_dec),
        .begin_cnt (desc_q.begin_cnt),
        .count     (cur_cnt),
        .last      (cnt_last),
        .half_hit  (cnt_half)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (kick)
                    state_d = ST_FETCH;
                else if (go)
                    state_d = ST_CHECK;
            end
            ST_FETCH: begin
                if (mem_gnt && fetch_last)
                    state_d = ST_CHECK;
            end
            ST_CHECK: begin
                if (desc_q.start && cfg_ok)
                    state_d = ST_READ;
                else
                    state_d = ST_IDLE;
            end
            ST_READ: begin
                if (mem_gnt)
                    state_d = ST_WRITE;
            end
            ST_WRITE: begin
                if (mem_gnt)
                    state_d = minor_last_bead ? ST_MINOR : ST_READ;
            end
            ST_MINOR: begin
                if (!cnt_last)
                    state_d = ST_READ;
                else if (desc_q.chain)
                    state_d = ST_FETCH;
                else
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // port outputs from state
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = 32'd0;
        mem_size  = 3'd0;
        mem_wdata = '0;
        mem_be    = '0;
        unique case (state_q)
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = fptr_q + {{(30 - WIDX_W){1'b0}}, widx_q, 2'b00};
                mem_size = 3'd2;
            end
            ST_READ: begin
                mem_req  = 1'b1;
                mem_addr = desc_q.src;
                mem_size = desc_q.src_code;
            end
            ST_WRITE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_q.dst;
                mem_size  = desc_q.dst_code;
                mem_wdata = rdbuf_q;
                mem_be    = be_all;
            end
            default: ;
        endcase
    end

    assign active  = active_q;
    assign done    = done_q;
    assign irq     = irq_q;
    assign cfg_err = err_q;

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            desc_q    <= '0;
            fptr_q    <= 32'd0;
            widx_q    <= '0;
            remain_q  <= 32'd0;
            rdbuf_q   <= '0;
            chained_q <= 1'b0;
            active_q  <= 1'b0;
            done_q    <= 1'b0;
            irq_q     <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (kick) begin
                        fptr_q    <= kick_addr;
                        widx_q    <= '0;
                        chained_q <= 1'b0;
                        done_q    <= 1'b0;
                        err_q     <= 1'b0;
                    end else if (go) begin
                        desc_q.start <= 1'b1;
                        chained_q    <= 1'b0;
                        done_q       <= 1'b0;
                        err_q        <= 1'b0;
                    end
                end
                ST_FETCH: begin
                    if (mem_gnt) begin
                        widx_q <= widx_q + WIDX_W'(1);
                        case (widx_q)
                            3'd0: desc_q.src     <= word;
                            3'd1: desc_q.dst     <= word;
                            3'd2: desc_q.nbytes  <= word;
                            3'd3: desc_q.src_adj <= word;
                            3'd4: desc_q.dst_adj <= word;
                            3'd5: begin
                                desc_q.src_step <= word[31:16];
                                desc_q.dst_step <= word[15:0];
                            end
                            3'd6: desc_q.begin_cnt <= word[CNT_W-1:0];
                            default: begin
                                desc_q.src_code  <= word[2:0];
                                desc_q.dst_code  <= word[6:4];
                                desc_q.start     <= word[FLG_START];
                                desc_q.chain     <= word[FLG_CHAIN];
                                desc_q.irq_major <= word[FLG_IMAJ];
                                desc_q.irq_half  <= word[FLG_IHALF];
                            end
                        endcase
                    end
                end
                ST_CHECK: begin
                    if (!desc_q.start) begin
                        done_q   <= chained_q;
                        active_q <= 1'b0;
                    end else if (!cfg_ok) begin
                        err_q    <= 1'b1;
                        active_q <= 1'b0;
                    end else begin
                        active_q <= 1'b1;
                        remain_q <= desc_q.nbytes;
                    end
                end
                ST_READ: begin
                    if (mem_gnt)
                        rdbuf_q <= mem_rdata;
                end
                ST_WRITE: begin
                    if (mem_gnt) begin
                        desc_q.src <= desc_q.src + {{16{desc_q.src_step[15]}}, desc_q.src_step};
                        desc_q.dst <= desc_q.dst + {{16{desc_q.dst_step[15]}}, desc_q.dst_step};
                        remain_q   <= remain_q - {26'd0, bead};
                    end
                end
                ST_MINOR: begin
                    irq_q <= (cnt_half && desc_q.irq_half) || (cnt_last && desc_q.irq_major);
                    if (!cnt_last) begin
                        remain_q <= desc_q.nbytes;
                    end else if (desc_q.chain) begin
                        fptr_q    <= desc_q.dst_adj;
                        widx_q    <= '0;
                        chained_q <= 1'b1;
                    end else begin
                        desc_q.src <= desc_q.src + desc_q.src_adj;
                        desc_q.dst <= desc_q.dst + desc_q.dst_adj;
                        done_q     <= 1'b1;
                        active_q   <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/dmae_chk.sv
module dmae_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic        mem_gnt,
    input logic        active,
    input logic        done,
    input logic        irq,
    input logic        cfg_err
);
    a_r13_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    a_r12_active_excl_done: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> !done);

    a_r12_write_active: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> active);

    a_r11_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !active && !mem_req);

    a_r7_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req);

    a_r9_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> !active && !done && !irq && !cfg_err);
endmodule

bind dmae_channel dmae_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_gnt  (mem_gnt),
    .active   (active),
    .done     (done),
    .irq      (irq),
    .cfg_err  (cfg_err)
);

// File: tb/dmae_channel_tb_top.sv
module dmae_channel_tb_top;
    localparam int DATA_W    = 256;
    localparam int LANES     = DATA_W / 8;
    localparam int MEM_BYTES = 8192;
    localparam logic [31:0] AMASK = 32'(MEM_BYTES - 1);

    typedef struct {
        int src, dst, nbytes, sadj, dadj, sstep, dstep, citer, biter, scode, dcode;
        bit start, chain, imaj, ihalf;
    } tdesc_t;

    logic clk = 1'b0, rst_n = 1'b0, kick = 1'b0, go = 1'b0, mem_gnt = 1'b1;
    logic [31:0] kick_addr = 32'd0;
    logic mem_req, mem_we, active, done, irq, cfg_err;
    logic [31:0] mem_addr;
    logic [2:0] mem_size;
    logic [DATA_W-1:0] mem_wdata, mem_rdata;
    logic [LANES-1:0] mem_be;

    always #2 clk = ~clk;

    dmae_channel #(.DATA_W(DATA_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .kick(kick), .kick_addr(kick_addr), .go(go),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .active(active), .done(done), .irq(irq), .cfg_err(cfg_err)
    );

    logic [7:0] mem [0:MEM_BYTES-1];
    logic [7:0] exp_mem [0:MEM_BYTES-1];

    always_comb begin
        for (int i = 0; i < LANES; i++)
            mem_rdata[8*i +: 8] = mem[13'((mem_addr + 32'(i)) & AMASK)];
    end

    always @(posedge clk) begin
        if (mem_req && mem_we && mem_gnt)
            for (int i = 0; i < LANES; i++)
                if (mem_be[i]) mem[13'((mem_addr + 32'(i)) & AMASK)] <= mem_wdata[8*i +: 8];
    end

    always @(negedge clk) mem_gnt <= ($urandom_range(0, 3) != 0);

    int n_chk = 0, n_err = 0, irq_total = 0, act_bad = 0, hold_bad = 0;
    bit hold_pend = 0;
    logic [31:0] hold_addr;
    logic hold_we;

    always @(posedge clk) begin
        if (rst_n) begin
            if (irq) irq_total++;
            if (mem_req && mem_we && !active) act_bad++;
            if (hold_pend && (!mem_req || mem_addr != hold_addr || mem_we != hold_we)) hold_bad++;
            hold_pend = mem_req && !mem_gnt;
            hold_addr = mem_addr;
            hold_we   = mem_we;
        end
    end

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int sz(input int code);
        case (code)
            0: return 1;
            1: return 2;
            2: return 4;
            4: return 16;
            5: return 32;
            default: return 0;
        endcase
    endfunction

    task automatic put32(input logic [31:0] a, input logic [31:0] v);
        for (int k = 0; k < 4; k++) mem[13'((a + 32'(k)) & AMASK)] = v[8*k +: 8];
    endtask

    function automatic logic [31:0] get32e(input logic [31:0] a);
        logic [31:0] v;
        for (int k = 0; k < 4; k++) v[8*k +: 8] = exp_mem[13'((a + 32'(k)) & AMASK)];
        return v;
    endfunction

    task automatic put_desc(input logic [31:0] a, input tdesc_t d);
        logic [31:0] w5, w6, w7;
        w5 = {d.sstep[15:0], d.dstep[15:0]};
        w6 = {7'd0, d.citer[8:0], 7'd0, d.biter[8:0]};
        w7 = {20'd0, d.ihalf, d.imaj, d.chain, d.start, 1'b0, d.dcode[2:0], 1'b0, d.scode[2:0]};
        put32(a, d.src); put32(a + 4, d.dst); put32(a + 8, d.nbytes);
        put32(a + 12, d.sadj); put32(a + 16, d.dadj);
        put32(a + 20, w5); put32(a + 24, w6); put32(a + 28, w7);
    endtask

    function automatic tdesc_t mk(input int s, input int d, input int nb, input int code, input int cnt);
        tdesc_t r;
        r.src = s; r.dst = d; r.nbytes = nb; r.sadj = 0; r.dadj = 0;
        r.sstep = sz(code); r.dstep = sz(code); r.citer = cnt; r.biter = cnt;
        r.scode = code; r.dcode = code; r.start = 1; r.chain = 0; r.imaj = 0; r.ihalf = 0;
        return r;
    endfunction

    task automatic fill(input int base, input int len);
        for (int i = 0; i < len; i++) mem[13'((32'(base) + 32'(i)) & AMASK)] = 8'($urandom);
    endtask

    // reference model state
    tdesc_t md;
    logic [31:0] m_s, m_d;
    int m_cnt, e_irq;
    bit e_done, e_err;

    task automatic model(input logic [31:0] a0, input bit from_go);
        logic [31:0] a, w5, w6, w7;
        bit chained, fg;
        int cnt, bb, r;
        a = a0; chained = 0; fg = from_go;
        e_irq = 0; e_done = 0; e_err = 0;
        forever begin
            if (!fg) begin
                md.src = get32e(a); md.dst = get32e(a + 4); md.nbytes = get32e(a + 8);
                md.sadj = get32e(a + 12); md.dadj = get32e(a + 16);
                w5 = get32e(a + 20); w6 = get32e(a + 24); w7 = get32e(a + 28);
                md.sstep = int'($signed(w5[31:16])); md.dstep = int'($signed(w5[15:0]));
                md.citer = int'(w6[24:16]); md.biter = int'(w6[8:0]);
                md.scode = int'(w7[2:0]); md.dcode = int'(w7[6:4]);
                md.start = w7[8]; md.chain = w7[9]; md.imaj = w7[10]; md.ihalf = w7[11];
                m_s = md.src; m_d = md.dst; cnt = md.citer;
            end else begin
                md.start = 1; cnt = m_cnt;
            end
            fg = 0;
            if (!md.start) begin e_done = chained; return; end
            bb = sz(md.scode);
            if (bb == 0 || md.scode != md.dcode || md.nbytes == 0 || cnt == 0 || (md.nbytes % bb) != 0) begin
                e_err = 1; return;
            end
            for (int it = 0; it < cnt; it++) begin
                for (int b = 0; b < md.nbytes / bb; b++) begin
                    for (int k = 0; k < bb; k++)
                        exp_mem[13'((m_d + 32'(k)) & AMASK)] = exp_mem[13'((m_s + 32'(k)) & AMASK)];
                    m_s = m_s + 32'(md.sstep);
                    m_d = m_d + 32'(md.dstep);
                end
                r = cnt - 1 - it;
                if (md.ihalf && r != 0 && r == (md.biter >> 1)) e_irq++;
            end
            if (md.imaj) e_irq++;
            if (md.chain) begin
                a = 32'(md.dadj); chained = 1;
            end else begin
                m_s = m_s + 32'(md.sadj); m_d = m_d + 32'(md.dadj);
                m_cnt = md.biter; e_done = 1; return;
            end
        end
    endtask

    task automatic run(input string tag, input logic [31:0] a, input bit use_go, input bit finishes);
        int irq0, bad;
        for (int i = 0; i < MEM_BYTES; i++) exp_mem[i] = mem[i];
        model(a, use_go);
        irq0 = irq_total;
        @(negedge clk);
        if (use_go) go = 1'b1; else begin kick = 1'b1; kick_addr = a; end
        @(negedge clk);
        kick = 1'b0; go = 1'b0;
        if (finishes) begin
            for (int n = 0; n < 20000; n++) begin
                if (done || cfg_err) break;
                @(negedge clk);
            end
            repeat (2) @(negedge clk);
        end else begin
            repeat (100) @(negedge clk);
        end
        chk(tag, "done", done, e_done);
        chk(tag, "cfg_err", cfg_err, e_err);
        chk(tag, "active after stop", active, 0);
        chk(tag, "irq count", irq_total - irq0, e_irq);
        bad = -1;
        for (int i = 0; i < MEM_BYTES; i++) if (bad < 0 && mem[i] !== exp_mem[i]) bad = i;
        if (bad < 0) chk(tag, "memory", 0, 0);
        else chk(tag, $sformatf("memory byte 0x%0h", bad), mem[bad], exp_mem[bad]);
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        tdesc_t d, e;
        int codes[5];
        codes = '{0, 1, 2, 4, 5};
        void'($urandom(32'h00C0FFEE));
        for (int i = 0; i < MEM_BYTES; i++) mem[i] = 8'(i * 7);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "active", active, 0); chk("R1", "done", done, 0);
        chk("R1", "irq", irq, 0); chk("R1", "cfg_err", cfg_err, 0); chk("R1", "mem_req", mem_req, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R4 R6 R9: basic 4-byte copy with major interrupt
        fill(32'h400, 64);
        d = mk(32'h400, 32'h1000, 16, 2, 1); d.imaj = 1;
        put_desc(32'h000, d); run("R2_R4_R9 basic", 32'h000, 0, 1);

        // R4 R6: every size code, two major iterations, no interrupt
        for (int i = 0; i < 5; i++) begin
            d = mk(32'h500 + 32'(i * 128), 32'h1100 + 32'(i * 128), 2 * sz(codes[i]), codes[i], 2);
            put_desc(32'h020, d); run($sformatf("R4_R6 code %0d", codes[i]), 32'h020, 0, 1);
        end

        // R5: negative source step, strided destination
        d = mk(32'h8F0, 32'h1400, 32, 2, 1); d.sstep = -4; d.dstep = 8;
        put_desc(32'h040, d); run("R5 signed steps", 32'h040, 0, 1);

        // R7: end adjustments, count reload, then go restart
        d = mk(32'h900, 32'h1500, 8, 1, 3); d.biter = 2; d.sadj = 32'h40; d.dadj = 32'h80; d.imaj = 1;
        put_desc(32'h060, d); run("R7 first run", 32'h060, 0, 1);
        run("R7 go restart", 32'h060, 1, 1);

        // R10: half interrupt
        d = mk(32'hA00, 32'h1700, 4, 2, 4); d.ihalf = 1; d.imaj = 1;
        put_desc(32'h080, d); run("R10 half+major", 32'h080, 0, 1);
        d = mk(32'hA40, 32'h1740, 4, 2, 1); d.ihalf = 1;
        put_desc(32'h080, d); run("R10 single iteration no half", 32'h080, 0, 1);

        // R8: three-descriptor chain
        d = mk(32'hB00, 32'h1800, 8, 2, 1); d.chain = 1; d.dadj = 32'h140; d.imaj = 1;
        put_desc(32'h100, d);
        d = mk(32'hB40, 32'h1840, 16, 4, 2); d.chain = 1; d.dadj = 32'h180;
        put_desc(32'h140, d);
        d = mk(32'hB80, 32'h1880, 6, 1, 1); d.imaj = 1;
        put_desc(32'h180, d);
        run("R8 chain of three", 32'h100, 0, 1);
        // R8: chain ends on a clear start bit
        d = mk(32'hBC0, 32'h18C0, 8, 2, 1); d.chain = 1; d.dadj = 32'h200;
        put_desc(32'h1C0, d);
        e = mk(32'hBE0, 32'h18E0, 8, 2, 1); e.start = 0;
        put_desc(32'h200, e);
        run("R8 chain stop", 32'h1C0, 0, 1);

        // R11: configuration errors
        d = mk(32'hC00, 32'h1900, 6, 2, 1); put_desc(32'h220, d); run("R11 nbytes not multiple", 32'h220, 0, 1);
        d = mk(32'hC00, 32'h1900, 8, 2, 0); put_desc(32'h220, d); run("R11 zero count", 32'h220, 0, 1);
        d = mk(32'hC00, 32'h1900, 8, 3, 1); put_desc(32'h220, d); run("R11 bad code", 32'h220, 0, 1);
        d = mk(32'hC00, 32'h1900, 8, 2, 1); d.dcode = 1; put_desc(32'h220, d); run("R11 size mismatch", 32'h220, 0, 1);
        d = mk(32'hC00, 32'h1900, 0, 2, 1); put_desc(32'h220, d); run("R11 zero bytes", 32'h220, 0, 1);

        // R3: start bit clear
        d = mk(32'hC00, 32'h1900, 8, 2, 1); d.start = 0;
        put_desc(32'h240, d); run("R3 no start", 32'h240, 0, 0);

        // random descriptors, some chained
        for (int t = 0; t < 24; t++) begin
            int c;
            c = codes[$urandom_range(0, 4)];
            fill(32'hD00, 512);
            d = mk(32'hD00, 32'h1A00, sz(c) * $urandom_range(1, 4), c, $urandom_range(1, 3));
            if ($urandom_range(0, 1) == 1) d.sstep = 2 * sz(c);
            d.imaj = 1'($urandom); d.ihalf = 1'($urandom);
            d.sadj = $urandom_range(0, 64);
            if ($urandom_range(0, 2) == 0) begin
                d.chain = 1; d.dadj = 32'h2C0;
                e = mk(32'hE80, 32'h1D00, sz(c) * $urandom_range(1, 3), c, $urandom_range(1, 3));
                e.imaj = 1'($urandom); e.ihalf = 1'($urandom);
                put_desc(32'h2C0, e);
            end else begin
                d.dadj = $urandom_range(0, 64);
            end
            put_desc(32'h2A0, d);
            run($sformatf("R5_R6_R8_R9_R10 random %0d", t), 32'h2A0, 0, 1);
        end

        chk("R12", "writes outside active", act_bad, 0);
        chk("R13", "request changed before grant", hold_bad, 0);
        summary();
        $finish;
    end
endmodule